// File: doc/BRIEF.md
# Key Row Gathering Sequencer

This block assembles a secret key out of a run of consecutive fuse rows. When started, it walks from a start row toward an end row. For each row it sends one read to an external fuse read port and waits for the answer before sending the next. A row that comes back marked as an ECC error or a failed row is passed over. Every other row gives its 32 data bits to the external key store as the next key word, together with that word's index.

The walk stops when the requested number of words has been collected, or when the row pointer passes the end row. The block then gives a one-cycle done pulse and a pass/fail verdict. The verdict is fail in three cases: the gathered words OR together to zero, they AND together to all ones, or the row range ran out. An empty request therefore always fails, because the AND accumulator keeps its all-ones start value.

Top module: `keygather_top`

## Requirements
- R1: A start pulse taken while idle captures the start row, the end row and the word count, and raises `busy` on the next cycle. The first read request carries the start row. Word counts above `KEY_MAX_WORDS` are treated as `KEY_MAX_WORDS`.
- R2: Read requests carry rows that rise by exactly one after every answered read, whether the row was good or bad. No request ever names a row above the end row.
- R3: At most one read is outstanding. After `rdReq` no new request appears until `rdValid` has answered it. `rdValid` is only acted on while a read is outstanding, and the answer may come one or more cycles after the request.
- R4: A returned row with `rdEccErr` or `rdFailFlag` set produces no key write and does not use up a word of the requested count.
- R5: A good row causes `keyWrEn` in the same cycle as its `rdValid`. `keyWrData` equals `rdData`, and `keyWrIdx` counts 0, 1, 2, … over the good rows of one run.
- R6: The run ends when the wanted word count reaches zero, or when the row pointer is past the end row, whichever happens first.
- R7: `pass` is 1 only if the AND of the accepted words is not all ones, their OR is not zero, and the row pointer has not passed the end row. This means that collecting the last word from the end row itself still gives fail.
- R8: `done` is high for exactly one cycle, in the cycle `pass` first shows the verdict. `pass` then holds until a new start is taken, which clears it to 0.
- R9: A start pulse while `busy` is high is ignored. The run in progress keeps its rows, its writes and its verdict.
- R10: A word count of zero issues no reads and ends with `done` and `pass` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to begin a run |
| startRow | input | ROW_W | First row to read |
| endRow | input | ROW_W | Last row that may be read |
| keyWords | input | CNT_W | Number of 32-bit words wanted (clamped to KEY_MAX_WORDS) |
| rdReq | output | 1 | One-cycle read request to the fuse port |
| rdRow | output | ROW_W | Row being requested |
| rdValid | input | 1 | Read answer strobe |
| rdData | input | DATA_W | Row data of the answer |
| rdEccErr | input | 1 | Answer flagged with an ECC error |
| rdFailFlag | input | 1 | Answer flagged as a failed row |
| keyWrEn | output | 1 | Key word write strobe |
| keyWrIdx | output | IDX_W | Index of the key word being written |
| keyWrData | output | DATA_W | Key word value |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Verdict of the last run |

## Verification
The collision that matters is a new start that lands in the very cycle `done` pulses for the previous run. The block is idle in that cycle, so it must accept the start, and the verdict just shown must be cleared on the following edge. The bench provokes this by launching the next run in the same cycle it observes `done` on every other run, and judges it by reading the old verdict in that cycle, then checking that `busy` is high, `pass` is low and the new first row is requested. A second overlap is the read answer that brings in the last needed word. In that one cycle the answer must produce the write, move the row pointer and end the run, and the bench judges this against a reference walk that also counts the requests.

// File: rtl/keygather_pkg.sv
`timescale 1ns/1ps
package keygather_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic load;    // capture run parameters, reset accumulators
    logic issue;   // a read request leaves this cycle
    logic take;    // answered row is good: store word, count it
    logic skip;    // answered row is bad: only move the row pointer
    logic finish;  // latch the verdict
  } seqStrobe_t;

endpackage

// File: rtl/keygather_datapath.sv
`timescale 1ns/1ps
module keygather_datapath
  import keygather_pkg::*;
#(
  parameter int ROW_W         = 10,
  parameter int DATA_W        = 32,
  parameter int KEY_MAX_WORDS = 16,
  parameter int CNT_W         = $clog2(KEY_MAX_WORDS + 1),
  parameter int IDX_W         = (KEY_MAX_WORDS > 1) ? $clog2(KEY_MAX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ROW_W-1:0]  startRow,
  input  logic [ROW_W-1:0]  endRow,
  input  logic [CNT_W-1:0]  keyWords,
  input  logic [DATA_W-1:0] rdData,
  output logic              moreWork,
  output logic [ROW_W-1:0]  rdRow,
  output logic [IDX_W-1:0]  keyWrIdx,
  output logic [DATA_W-1:0] keyWrData,
  output logic              pass
);

  localparam int PTR_W = ROW_W + 1;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(KEY_MAX_WORDS);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  // One extra bit so the pointer can step past the highest row.
  logic [PTR_W-1:0]  rowPtr;
  logic [ROW_W-1:0]  endReg;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  idxCnt;
  logic [DATA_W-1:0] orAcc;
  logic [DATA_W-1:0] andAcc;
  logic              passReg;

  logic [CNT_W-1:0] loadCount;
  logic             pastEnd;
  logic             verdict;

  assign loadCount = (keyWords > MAX_CNT) ? MAX_CNT : keyWords;
  assign pastEnd   = rowPtr > {1'b0, endReg};
  assign moreWork  = (remain != '0) && !pastEnd;
  assign verdict   = (andAcc != ALL_ONES) && (orAcc != '0) && !pastEnd;

  assign rdRow     = rowPtr[ROW_W-1:0];
  assign keyWrIdx  = idxCnt[IDX_W-1:0];
  assign keyWrData = rdData;
  assign pass      = passReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowPtr  <= '0;
      endReg  <= '0;
      remain  <= '0;
      idxCnt  <= '0;
      orAcc   <= '0;
      andAcc  <= ALL_ONES;
      passReg <= 1'b0;
    end else begin
      if (strobe.load) begin
        rowPtr  <= {1'b0, startRow};
        endReg  <= endRow;
        remain  <= loadCount;
        idxCnt  <= '0;
        orAcc   <= '0;
        andAcc  <= ALL_ONES;
        passReg <= 1'b0;
      end
      if (strobe.take) begin
        orAcc  <= orAcc | rdData;
        andAcc <= andAcc & rdData;
        remain <= remain - CNT_W'(1);
        idxCnt <= idxCnt + CNT_W'(1);
      end
      if (strobe.take || strobe.skip) begin
        rowPtr <= rowPtr + PTR_W'(1);
      end
      if (strobe.finish) begin
        passReg <= verdict;
      end
    end
  end

  // R2: a request never names a row above the captured end row
  assert_row_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (rowPtr <= {1'b0, endReg}));

  // R2: every answered read moves the pointer by exactly one
  assert_row_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take || strobe.skip) |=> (rowPtr == $past(rowPtr) + PTR_W'(1)));

  // R4: a bad row leaves the wanted count untouched
  assert_bad_row_uncounted_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.skip |=> (remain == $past(remain)));

  // R5: a word is only stored while words are still wanted
  assert_write_within_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> (remain != '0));

  // R8: verdict only moves on finish or on a new load
  assert_pass_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.finish && !strobe.load) |=> $stable(passReg));

endmodule

// File: rtl/keygather_control.sv
`timescale 1ns/1ps
module keygather_control
  import keygather_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       moreWork,
  input  logic       rdValid,
  input  logic       rdBad,
  output seqStrobe_t strobe,
  output logic       rdReq,
  output logic       keyWrEn,
  output logic       busy,
  output logic       done
);

  seqState_t state;
  seqState_t stateNext;
  logic      doneReg;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.load = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (moreWork) begin
          strobe.issue = 1'b1;
          stateNext    = ST_WAIT;
        end else begin
          strobe.finish = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (rdValid) begin
          strobe.take = !rdBad;
          strobe.skip = rdBad;
          stateNext   = ST_CHECK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= strobe.finish;
    end
  end

  assign rdReq   = strobe.issue;
  assign keyWrEn = strobe.take;
  assign busy    = (state != ST_IDLE);
  assign done    = doneReg;

  // Outstanding-read tracker, used by the check below.
  logic inFlight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= 1'b0;
    else if (rdReq) inFlight <= 1'b1;
    else if (rdValid) inFlight <= 1'b0;
  end

  // R3: no new request while one is unanswered
  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !inFlight);

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a start while busy does not restart the run
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |-> !strobe.load);

endmodule

// File: rtl/keygather_top.sv
`timescale 1ns/1ps
module keygather_top
  import keygather_pkg::*;
#(
  parameter int ROW_W         = 10,
  parameter int DATA_W        = 32,
  parameter int KEY_MAX_WORDS = 16,
  parameter int CNT_W         = $clog2(KEY_MAX_WORDS + 1),
  parameter int IDX_W         = (KEY_MAX_WORDS > 1) ? $clog2(KEY_MAX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ROW_W-1:0]  startRow,
  input  logic [ROW_W-1:0]  endRow,
  input  logic [CNT_W-1:0]  keyWords,
  output logic              rdReq,
  output logic [ROW_W-1:0]  rdRow,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdEccErr,
  input  logic              rdFailFlag,
  output logic              keyWrEn,
  output logic [IDX_W-1:0]  keyWrIdx,
  output logic [DATA_W-1:0] keyWrData,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  seqStrobe_t strobe;
  logic       moreWork;
  logic       rdBad;

  assign rdBad = rdEccErr | rdFailFlag;

  keygather_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .moreWork (moreWork),
    .rdValid  (rdValid),
    .rdBad    (rdBad),
    .strobe   (strobe),
    .rdReq    (rdReq),
    .keyWrEn  (keyWrEn),
    .busy     (busy),
    .done     (done)
  );

  keygather_datapath #(
    .ROW_W         (ROW_W),
    .DATA_W        (DATA_W),
    .KEY_MAX_WORDS (KEY_MAX_WORDS),
    .CNT_W         (CNT_W),
    .IDX_W         (IDX_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startRow  (startRow),
    .endRow    (endRow),
    .keyWords  (keyWords),
    .rdData    (rdData),
    .moreWork  (moreWork),
    .rdRow     (rdRow),
    .keyWrIdx  (keyWrIdx),
    .keyWrData (keyWrData),
    .pass      (pass)
  );

endmodule

// File: tb/test_keygather_top.sv
`timescale 1ns/1ps
module test_keygather_top;

  localparam int ROW_W = 10;
  localparam int DATA_W = 32;
  localparam int KMAX = 16;
  localparam int CNT_W = $clog2(KMAX + 1);
  localparam int IDX_W = $clog2(KMAX);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [ROW_W-1:0] startRow = '0;
  logic [ROW_W-1:0] endRow = '0;
  logic [CNT_W-1:0] keyWords = '0;
  logic rdReq;
  logic [ROW_W-1:0] rdRow;
  logic rdValid = 1'b0;
  logic [DATA_W-1:0] rdData = '0;
  logic rdEccErr = 1'b0;
  logic rdFailFlag = 1'b0;
  logic keyWrEn;
  logic [IDX_W-1:0] keyWrIdx;
  logic [DATA_W-1:0] keyWrData;
  logic busy, done, pass;

  always #2 clk = ~clk;

  keygather_top i_keygather_top (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startRow(startRow),
    .endRow(endRow), .keyWords(keyWords), .rdReq(rdReq), .rdRow(rdRow),
    .rdValid(rdValid), .rdData(rdData), .rdEccErr(rdEccErr),
    .rdFailFlag(rdFailFlag), .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx),
    .keyWrData(keyWrData), .busy(busy), .done(done), .pass(pass)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int curMode = 0;
  logic [7:0] curBad = '0;
  int expRow = 0;
  int writesSeen = 0;
  int reqSeen = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rowValue(input int row, input int mode);
    case (mode)
      0: return 32'(row) * 32'h9E3779B1 + 32'h1234;
      1: return 32'h0;
      2: return 32'hFFFFFFFF;
      default: return (row % 2 != 0) ? 32'hFFFFFFFF : 32'h0;
    endcase
  endfunction

  function automatic bit rowBad(input int row, input logic [7:0] m);
    return m[row % 8];
  endfunction

  // Fuse read port model: latency 1..3 cycles, one answer per request.
  initial begin
    @(negedge clk);
    forever begin
      if (rdReq) begin
        automatic int r = int'(rdRow);
        automatic int lat = 1 + (r % 3);
        automatic bit bad = rowBad(r, curBad);
        automatic logic [31:0] v = rowValue(r, curMode);
        check(r == expRow, "R2", "requested row", 32'(r), 32'(expRow));
        reqSeen++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          check(!rdReq, "R3", "request while outstanding", 32'(rdReq), 32'h0);
        end
        rdValid = 1'b1;
        rdData = v;
        rdEccErr = bad && (r % 2 == 0);
        rdFailFlag = bad && (r % 2 != 0);
        #1;
        if (bad) begin
          check(!keyWrEn, "R4", "write on bad row", 32'(keyWrEn), 32'h0);
        end else begin
          check(keyWrEn, "R5", "write on good row", 32'(keyWrEn), 32'h1);
          check(int'(keyWrIdx) == writesSeen, "R5", "key index",
                32'(keyWrIdx), 32'(writesSeen));
          check(keyWrData == v, "R5", "key data", keyWrData, v);
          writesSeen++;
        end
        expRow = r + 1;
        @(negedge clk);
        rdValid = 1'b0;
        rdEccErr = 1'b0;
        rdFailFlag = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Caller is at a negedge. linger=0 returns in the done cycle so the
  // next run starts in that same cycle.
  task automatic runCase(input int sr, input int er, input int kw,
                         input int mode, input logic [7:0] bad,
                         input bit linger, input bit poke);
    int rem, row, nAcc, cyc;
    logic [31:0] orA, andA;
    bit expPass, sawDone;
    rem = (kw > KMAX) ? KMAX : kw;
    row = sr; nAcc = 0; orA = '0; andA = '1;
    while (rem > 0 && row <= er) begin
      if (!rowBad(row, bad)) begin
        orA |= rowValue(row, mode);
        andA &= rowValue(row, mode);
        rem--; nAcc++;
      end
      row++;
    end
    expPass = (andA != 32'hFFFFFFFF) && (orA != 0) && (row <= er);

    curMode = mode; curBad = bad; expRow = sr; writesSeen = 0; reqSeen = 0;
    startRow = ROW_W'(sr); endRow = ROW_W'(er); keyWords = CNT_W'(kw);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy, "R1", "busy after start", 32'(busy), 32'h1);
    check(!pass, "R8", "pass cleared by start", 32'(pass), 32'h0);

    cyc = 0; sawDone = 0;
    while (!sawDone && cyc < 5000) begin
      if (done) sawDone = 1;
      else if (poke && cyc == 2 && busy) begin
        startRow = ~startRow; keyWords = CNT_W'(3); startReq = 1'b1;
        @(negedge clk);
        startReq = 1'b0; startRow = ROW_W'(sr); keyWords = CNT_W'(kw);
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    check(sawDone, "R6", "run ended", 32'(sawDone), 32'h1);
    check(pass == expPass, poke ? "R9" : "R7", "verdict", 32'(pass), 32'(expPass));
    check(writesSeen == nAcc, "R6", "words written", 32'(writesSeen), 32'(nAcc));
    check(reqSeen == row - sr, "R2", "rows requested", 32'(reqSeen), 32'(row - sr));
    if (kw == 0) begin
      check(reqSeen == 0 && !pass, "R10", "empty request", 32'(reqSeen), 32'h0);
    end
    if (linger) begin
      @(negedge clk);
      check(!done, "R8", "done one cycle", 32'(done), 32'h0);
      check(pass == expPass && !busy, "R8", "verdict held", 32'(pass), 32'(expPass));
      @(negedge clk);
      check(pass == expPass, "R8", "verdict still held", 32'(pass), 32'(expPass));
    end
  endtask

  initial begin
    int n;
    logic [7:0] masks [4];
    masks[0] = 8'h00; masks[1] = 8'h24; masks[2] = 8'hFF; masks[3] = 8'h5B;
    #1;
    check(!busy && !done && !pass && !rdReq && !keyWrEn, "R1", "reset state",
          {27'h0, busy, done, pass, rdReq, keyWrEn}, 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    n = 0;
    for (int mode = 0; mode < 4; mode++)
      for (int mi = 0; mi < 4; mi++)
        for (int sr = 0; sr < 3; sr++)
          for (int d = -1; d < 5; d++)
            for (int kw = 0; kw < 5; kw++) begin
              if (sr + d >= 0) begin
                runCase(sr, sr + d, kw, mode, masks[mi], n % 2 == 1, n % 5 == 0);
                n++;
              end
            end
    // R6/R7: range runs out at the highest row; pointer must step past it
    runCase(1020, 1023, 16, 0, 8'h00, 1'b1, 1'b0);
    // R1: count above the maximum is clamped, range large enough to pass
    runCase(0, 30, 20, 0, 8'h00, 1'b1, 1'b0);
    // R7: last word from the end row itself still fails
    runCase(4, 7, 4, 0, 8'h00, 1'b1, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule